// File: doc/BRIEF.md
# Sinc Filter Built-In Self-Test Wrapper

This block wraps a decimating Sinc filter channel with on-chip self-test logic. In normal operation it forwards the 5-bit modulator word to the filter untouched. When the test-mode-select input rises, it clears the filter registers, switches the filter input to an internal pattern source, and runs a toggle test. The test drives the filter with all-zeros, then all-ones, then all-zeros words. After each window it compares the 21-bit filter output against a stored expected word. Every output bit must therefore fall and rise at least once, which exposes stuck-at-0 and stuck-at-1 faults on the output path.

The filter itself sits outside the wrapper and is reached through ports. The wrapper returns three results:
- one pass bit per check;
- a sticky error flag, which an external error counter uses to count failing runs;
- a single-cycle end-of-test pulse.

The sequencer has five states:
- IDLE waits for a rising edge of test-mode-select. On that edge it goes to CLEAR and loads the 2-bit source selector with 11.
- CLEAR asserts the filter clear for one cycle and always moves to RUN.
- RUN applies the pattern for a parameterised number of cycles. When the interval counter reaches its last count, it moves to LATCH.
- LATCH compares the filter output and stores the result. It returns to RUN for the next check, or goes to DONE after the third check.
- DONE issues the end-of-test pulse, returns the selector to 00 and goes back to IDLE.

Top module: `sinc_bist_wrap`

## Requirements
- R1: After reset, test_done_o is 0, test_fail_o is 0, pass_o is 000, and filt_in_o equals mod_data_i.
- R2: While no test runs, the source selector is 00 and filt_in_o follows mod_data_i combinationally. From the start edge until the end-of-test pulse, the selector is 11 and filt_in_o carries only the pattern word.
- R3: A rising edge on tms_i while idle starts a test. In the first cycle after that clock edge, filt_clr_o is high for exactly one cycle, and pass_o and test_fail_o are cleared. A further rising edge of tms_i during a running test is ignored: the test timing and results are unchanged.
- R4: The pattern word is 5'b00000 during the clear cycle and the windows of checks 0 and 2. It is 5'b11111 during the window of check 1.
- R5: Counting the start clock edge as edge 1, each check takes INTERVAL pattern cycles followed by one compare cycle. Check k is latched at edge 3+INTERVAL+k*(INTERVAL+1).
- R6: The expected outputs are 21'h000000, 21'h1FFFFF and 21'h000000 for checks 0, 1 and 2. pass_o bit k (bit 0 is check 0) is set exactly when check k matches.
- R7: If any check mismatches, test_fail_o goes to 1 and stays 1 until the next test start.
- R8: test_done_o is a one-cycle pulse in the cycle after the third check is latched, which is edge 5+3*INTERVAL. After it, filt_in_o again follows mod_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tms_i | input | 1 | Test-mode select; a rising edge starts a self-test |
| mod_data_i | input | IN_W | Modulator data for normal operation |
| filt_clr_o | output | 1 | Clears the filter registers at test start |
| filt_in_o | output | IN_W | Word driven into the filter |
| filt_out_i | input | OUT_W | Filter output word |
| pass_o | output | 3 | Per-check pass bits |
| test_done_o | output | 1 | One-cycle end-of-test pulse |
| test_fail_o | output | 1 | Sticky error flag |

## Verification
The bench builds the wrapper with the default 5-bit input and 21-bit output, and with INTERVAL set to 4. This makes a whole run take 17 cycles, so the bench can check the exact cycle of every pattern change, compare and end-of-test pulse. A behavioural filter model in the bench can force any single output bit stuck at 0 or 1. A stuck-at-0 bit must fail only the all-ones check, and a stuck-at-1 bit must fail only the two all-zeros checks. The short runs also leave room to pulse tms_i in the middle of a test and to watch the error flag persist across idle cycles.

// File: rtl/sinc_bist_pkg.sv
package sinc_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_LATCH,
        ST_DONE
    } bist_state_e;

    localparam logic [1:0] SEL_NORM = 2'b00;
    localparam logic [1:0] SEL_TEST = 2'b11;
    localparam int         N_CHECKS = 3;
    localparam logic [1:0] LAST_CHK = 2'd2;

    // Check index whose window uses the all-ones stimulus and expects an all-ones result
    function automatic logic ones_phase(input logic [1:0] idx);
        return idx == 2'd1;
    endfunction

endpackage

// File: rtl/sinc_bist_ctrl.sv
module sinc_bist_ctrl
    import sinc_bist_pkg::*;
#(
    parameter int INTERVAL = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms_i,
    output logic       start_o,
    output logic       clr_o,
    output logic       latch_o,
    output logic       done_o,
    output logic [1:0] sel_o,
    output logic [1:0] chk_o
);

    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

    bist_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       chk_q;
    logic [1:0]       sel_q;
    logic             tms_q;
    logic             start;
    logic             win_last;

    assign start    = (state_q == ST_IDLE) && tms_i && !tms_q;
    assign win_last = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_RUN;
            ST_RUN:   if (win_last) state_d = ST_LATCH;
            ST_LATCH: state_d = (chk_q == LAST_CHK) ? ST_DONE : ST_RUN;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers: edge detector, interval counter, check index, selector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms_q <= 1'b0;
            cnt_q <= '0;
            chk_q <= '0;
            sel_q <= SEL_NORM;
        end else begin
            tms_q <= tms_i;
            if (state_q == ST_RUN && !win_last) cnt_q <= cnt_q + 1'b1;
            else                                cnt_q <= '0;
            if (start) begin
                chk_q <= '0;
                sel_q <= SEL_TEST;
            end else if (state_q == ST_LATCH && chk_q != LAST_CHK) begin
                chk_q <= chk_q + 2'd1;
            end else if (state_q == ST_DONE) begin
                sel_q <= SEL_NORM;
            end
        end
    end

    // Moore outputs
    always_comb begin
        clr_o   = 1'b0;
        latch_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_o   = 1'b1;
            ST_LATCH: latch_o = 1'b1;
            ST_DONE:  done_o  = 1'b1;
            default: ;
        endcase
    end

    assign start_o = start;
    assign sel_o   = sel_q;
    assign chk_o   = chk_q;

    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (clr_o && sel_q == SEL_TEST));
    p_clear_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);
    p_sel_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (sel_q == SEL_TEST));
    p_latch_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> ($past(state_q) == ST_RUN && $past(win_last)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && sel_q == SEL_NORM));

endmodule

// File: rtl/sinc_bist_src.sv
module sinc_bist_src
    import sinc_bist_pkg::*;
#(
    parameter int IN_W = 5
) (
    input  logic [1:0]      sel_i,
    input  logic [1:0]      chk_i,
    input  logic [IN_W-1:0] mod_data_i,
    output logic [IN_W-1:0] filt_in_o
);

    logic [IN_W-1:0] pattern;

    // Pattern generator: only the all-ones and all-zeros words exist
    assign pattern = ones_phase(chk_i) ? {IN_W{1'b1}} : {IN_W{1'b0}};

    always_comb begin
        if (sel_i == SEL_TEST) filt_in_o = pattern;
        else                   filt_in_o = mod_data_i;
    end

    always_comb begin
        if (sel_i == SEL_TEST)
            p_pattern_only_r4: assert (filt_in_o == '0 || filt_in_o == '1);
    end

endmodule

// File: rtl/sinc_bist_ora.sv
module sinc_bist_ora
    import sinc_bist_pkg::*;
#(
    parameter int OUT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             latch_i,
    input  logic [1:0]       chk_i,
    input  logic [OUT_W-1:0] filt_out_i,
    output logic [2:0]       pass_o,
    output logic             fail_o
);

    logic [OUT_W-1:0] exp_rom [N_CHECKS];
    logic [OUT_W-1:0] exp_word;
    logic             match;

    // Expected-word ROM, one entry per check
    for (genvar g = 0; g < N_CHECKS; g++) begin : g_rom
        assign exp_rom[g] = ones_phase(2'(g)) ? {OUT_W{1'b1}} : {OUT_W{1'b0}};
    end

    assign exp_word = (chk_i == 2'd0) ? exp_rom[0] :
                      (chk_i == 2'd1) ? exp_rom[1] : exp_rom[2];
    assign match    = (filt_out_i == exp_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_o <= '0;
            fail_o <= 1'b0;
        end else if (start_i) begin
            pass_o <= '0;
            fail_o <= 1'b0;
        end else if (latch_i) begin
            pass_o[chk_i] <= match;
            if (!match) fail_o <= 1'b1;
        end
    end

    p_fail_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && !match) |=> fail_o);
    p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);
    p_pass_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && match && chk_i == 2'd1) |=> pass_o[1]);

endmodule

// File: rtl/sinc_bist_wrap.sv
module sinc_bist_wrap
    import sinc_bist_pkg::*;
#(
    parameter int IN_W     = 5,
    parameter int OUT_W    = 21,
    parameter int INTERVAL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tms_i,
    input  logic [IN_W-1:0]  mod_data_i,
    output logic             filt_clr_o,
    output logic [IN_W-1:0]  filt_in_o,
    input  logic [OUT_W-1:0] filt_out_i,
    output logic [2:0]       pass_o,
    output logic             test_done_o,
    output logic             test_fail_o
);

    logic       start, latch;
    logic [1:0] sel, chk;

    sinc_bist_ctrl #(.INTERVAL(INTERVAL)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tms_i   (tms_i),
        .start_o (start),
        .clr_o   (filt_clr_o),
        .latch_o (latch),
        .done_o  (test_done_o),
        .sel_o   (sel),
        .chk_o   (chk)
    );

    sinc_bist_src #(.IN_W(IN_W)) u_src (
        .sel_i      (sel),
        .chk_i      (chk),
        .mod_data_i (mod_data_i),
        .filt_in_o  (filt_in_o)
    );

    sinc_bist_ora #(.OUT_W(OUT_W)) u_ora (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .latch_i    (latch),
        .chk_i      (chk),
        .filt_out_i (filt_out_i),
        .pass_o     (pass_o),
        .fail_o     (test_fail_o)
    );

    p_normal_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NORM) |-> (filt_in_o == mod_data_i));
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_done_o |-> ($past(latch) && $past(chk) == LAST_CHK));

endmodule

// File: tb/sinc_bist_wrap_tb.sv
module sinc_bist_wrap_tb;

    localparam int IN_W  = 5;
    localparam int OUT_W = 21;
    localparam int IV    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tms = 1'b0;
    logic [IN_W-1:0]  mod_data = 5'h13;
    logic             filt_clr;
    logic [IN_W-1:0]  filt_in;
    logic [OUT_W-1:0] filt_out, filt_raw;
    logic [OUT_W-1:0] s0_mask = '0, s1_mask = '0;
    logic [2:0]       pass;
    logic             done, fail;
    int               checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    sinc_bist_wrap #(.IN_W(IN_W), .OUT_W(OUT_W), .INTERVAL(IV)) u_dut (
        .clk (clk), .rst_n (rst_n), .tms_i (tms), .mod_data_i (mod_data),
        .filt_clr_o (filt_clr), .filt_in_o (filt_in), .filt_out_i (filt_out),
        .pass_o (pass), .test_done_o (done), .test_fail_o (fail)
    );

    // Behavioural filter model with fault injection on its output
    always_ff @(posedge clk) begin
        if (filt_clr)              filt_raw <= '0;
        else if (filt_in == '1)    filt_raw <= '1;
        else if (filt_in == '0)    filt_raw <= '0;
        else                       filt_raw <= {{(OUT_W-IN_W){1'b0}}, filt_in};
    end
    assign filt_out = (filt_raw & ~s0_mask) | s1_mask;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(done == 1'b0, "R1 done", 32'(done), 0);
        check(fail == 1'b0, "R1 fail", 32'(fail), 0);
        check(pass == 3'b000, "R1 pass", 32'(pass), 0);
        check(filt_in == mod_data, "R1 filt_in", 32'(filt_in), 32'(mod_data));
    endtask

    task automatic t_passthru();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            mod_data = 5'(i * 7 + 3);
            #1;
            check(filt_in == mod_data, "R2 passthrough", 32'(filt_in), 32'(mod_data));
        end
        mod_data = 5'h13;
    endtask

    // One full self-test run; poke raises tms again in the middle of the run
    task automatic t_run(input logic [2:0] exp_pass, input bit exp_fail, input bit poke);
        int done_at, done_cnt, clr_bad;
        done_at = -1; done_cnt = 0; clr_bad = 0;
        @(negedge clk);
        tms = 1'b1;
        for (int k = 1; k <= 3 * IV + 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin
                check(filt_clr == 1'b1, "R3 clear pulse", 32'(filt_clr), 1);
                check(pass == 3'b000 && fail == 1'b0, "R3 flags cleared",
                      32'({fail, pass}), 0);
                check(filt_in == '0, "R4 clear-cycle pattern", 32'(filt_in), 0);
            end else if (filt_clr) clr_bad++;
            if (k == 2) begin
                tms = 1'b0;
                check(filt_in == '0, "R4 check0 pattern", 32'(filt_in), 0);
            end
            if (poke && k == 8)  tms = 1'b1;
            if (poke && k == 9)  tms = 1'b0;
            if (k == 3 + IV)
                check(filt_in == '1, "R4 check1 pattern", 32'(filt_in), 32'h1f);
            if (k == 4 + 2 * IV)
                check(filt_in == '0, "R4 check2 pattern", 32'(filt_in), 0);
            if (k == 2 + IV)
                check(filt_in != mod_data || mod_data == '0, "R2 pattern not data",
                      32'(filt_in), 0);
            if (done) begin
                done_cnt++;
                done_at = k;
            end
        end
        check(clr_bad == 0, "R3 single clear", 32'(clr_bad), 0);
        check(done_at == 5 + 3 * IV, "R5 R8 done cycle", 32'(done_at), 32'(5 + 3 * IV));
        check(done_cnt == 1, "R8 done width", 32'(done_cnt), 1);
        check(pass == exp_pass, "R6 pass bits", 32'(pass), 32'(exp_pass));
        check(fail == exp_fail, "R7 fail flag", 32'(fail), 32'(exp_fail));
        check(filt_in == mod_data, "R8 back to data", 32'(filt_in), 32'(mod_data));
    endtask

    task automatic t_hold(input bit exp_fail);
        repeat (6) @(negedge clk);
        check(fail == exp_fail, "R7 flag holds", 32'(fail), 32'(exp_fail));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_run(3'b111, 1'b0, 1'b0);          // clean filter
        s0_mask = 21'h000080;                 // bit 7 stuck at 0
        t_run(3'b101, 1'b1, 1'b0);
        t_hold(1'b1);
        s0_mask = '0;
        s1_mask = 21'h100000;                 // bit 20 stuck at 1
        t_run(3'b010, 1'b1, 1'b0);
        s1_mask = '0;
        t_run(3'b111, 1'b0, 1'b1);          // clean, with mid-run tms pulse (R3)
        t_hold(1'b0);
        t_passthru();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule